// File: doc/BRIEF.md
# Conditional Immediate Register-Transfer Unit

This block is the execute stage of a small processor whose only data movement is the register transfer, with program flow steered by conditional transfers. It holds a sixteen-entry, sixteen-bit register file. It accepts a sixteen-bit instruction word together with an execute strobe. It carries out a plain copy between registers, a load of an eight-bit constant, or a conditional form of either. A conditional form writes only when the destination register currently holds zero, or only when it holds a non-zero value.

The condition is taken from the destination register's own contents at execute time. A zero test over all sixteen bits gates the enable of the destination write decoder. When the condition fails, the instruction still completes but writes nothing. The write port (enable, index, data) is visible at the ports. A combinational peek port lets the surrounding logic, or a bench, read any register.

A controller with two states sequences the work. `ST_IDLE` waits for the strobe. The transition `IDLE->EXEC` is taken when the strobe is sampled high, and the instruction word is latched at the same edge. In `ST_EXEC` the latched instruction is decoded and any write lands on the closing edge. From there, `EXEC->EXEC` is taken when a further strobe arrives (back-to-back execution) and `EXEC->IDLE` when it does not.

Top module: `cond_xfer_unit`

## Requirements
- R1: After reset, every register reads 0000 on the peek port and `wr_en` is low.
- R2: Opcode bits [15:12]=0001 (copy) with source in [11:8] and destination in [3:0] writes the source register's value into the destination.
- R3: Opcode 0010 (constant load) writes {8'h00, instr[11:4]} into the register at [3:0].
- R4: Opcode 0011 (copy if zero) performs the R2 copy only when the destination register is 0000; otherwise it writes nothing.
- R5: Opcode 0100 (copy if non-zero) performs the R2 copy only when the destination register is not 0000; otherwise it writes nothing.
- R6: Opcode 0101 (constant if zero) performs the R3 load only when the destination register is 0000.
- R7: Opcode 0110 (constant if non-zero) performs the R3 load only when the destination register is not 0000.
- R8: Any other opcode (0000, 0111 to 1111) leaves `wr_en` low and all registers unchanged.
- R9: A strobe sampled at clock edge k drives `wr_en`, `wr_idx` and `wr_data` during the cycle after k; the register changes at edge k+1; the condition uses the value before that write; strobes on consecutive edges each execute in turn.
- R10: While `exec_en` is low, no register is written, whatever is on `instr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Execute strobe; `instr` is latched when it is high at an edge |
| instr | input | 16 | Instruction word |
| peek_idx | input | 4 | Register index for the peek port |
| wr_en | output | 1 | Register write enable in the execute cycle |
| wr_idx | output | 4 | Destination register index |
| wr_data | output | 16 | Data being written |
| peek_data | output | 16 | Combinational read of register `peek_idx` |

## Verification
The write port is due one cycle after the strobe edge. The bench samples it at the falling edge that follows that edge. The register contents are due one edge later, so the peek port is read at the next falling edge. A test that says nothing is written therefore reads the destination after the point where the write would have landed. Back-to-back strobes check that the second condition sees the first instruction's result exactly one cycle later.

// File: rtl/cxu_pkg.sv
package cxu_pkg;
    localparam int INSTR_W = 16;
    localparam int OPC_W   = 4;
    localparam int IMM_W   = 8;

    localparam logic [OPC_W-1:0] OPC_COPY    = 4'd1;
    localparam logic [OPC_W-1:0] OPC_CONST   = 4'd2;
    localparam logic [OPC_W-1:0] OPC_COPY_Z  = 4'd3;
    localparam logic [OPC_W-1:0] OPC_COPY_NZ = 4'd4;
    localparam logic [OPC_W-1:0] OPC_CONST_Z = 4'd5;
    localparam logic [OPC_W-1:0] OPC_CONST_NZ= 4'd6;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } ctrl_state_t;
endpackage

// File: rtl/cxu_regfile.sv
module cxu_regfile #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [DATA_W-1:0] w_data,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [IDX_W-1:0]  peek_idx,
    output logic [DATA_W-1:0] src_val,
    output logic [DATA_W-1:0] dst_val,
    output logic [DATA_W-1:0] peek_val
);
    localparam int NREG = 1 << IDX_W;

    logic [DATA_W-1:0] mem [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (we && (w_idx == IDX_W'(g))) begin
                mem[g] <= w_data;
            end
        end
    end

    assign src_val  = mem[src_idx];
    assign dst_val  = mem[dst_idx];
    assign peek_val = mem[peek_idx];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we) |-> (mem[$past(w_idx)] == $past(w_data))); // R9
endmodule

// File: rtl/cxu_decode.sv
module cxu_decode
    import cxu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic [INSTR_W-1:0] ir,
    input  logic [DATA_W-1:0]  src_val,
    input  logic [DATA_W-1:0]  dst_val,
    output logic [IDX_W-1:0]   src_idx,
    output logic [IDX_W-1:0]   dst_idx,
    output logic               write_ok,
    output logic [DATA_W-1:0]  data
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic [OPC_W-1:0]  opc;
    logic [DATA_W-1:0] imm_ext;
    logic              dst_zero;

    assign opc      = ir[INSTR_W-1 -: OPC_W];
    assign src_idx  = ir[11:8];
    assign dst_idx  = ir[IDX_W-1:0];
    assign imm_ext  = {{PAD_W{1'b0}}, ir[11:4]};
    assign dst_zero = ~(|dst_val);

    always_comb begin
        write_ok = 1'b0;
        data     = src_val;
        case (opc)
            OPC_COPY:     begin write_ok = 1'b1;      data = src_val; end
            OPC_COPY_Z:   begin write_ok = dst_zero;  data = src_val; end
            OPC_COPY_NZ:  begin write_ok = !dst_zero; data = src_val; end
            OPC_CONST:    begin write_ok = 1'b1;      data = imm_ext; end
            OPC_CONST_Z:  begin write_ok = dst_zero;  data = imm_ext; end
            OPC_CONST_NZ: begin write_ok = !dst_zero; data = imm_ext; end
            default:      begin write_ok = 1'b0;      data = src_val; end
        endcase
    end
endmodule

// File: rtl/cxu_ctrl.sv
module cxu_ctrl
    import cxu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exec_en,
    input  logic [INSTR_W-1:0] instr,
    output logic [INSTR_W-1:0] ir,
    output logic               exec_active
);
    ctrl_state_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ir    <= '0;
        end else begin
            state <= state_nxt;
            if (exec_en) begin
                ir <= instr;
            end
        end
    end

    always_comb begin
        state_nxt   = state;
        exec_active = 1'b0;
        unique case (state)
            ST_IDLE: begin
                state_nxt = exec_en ? ST_EXEC : ST_IDLE;
            end
            ST_EXEC: begin
                exec_active = 1'b1;
                state_nxt   = exec_en ? ST_EXEC : ST_IDLE;
            end
        endcase
    end

    AST_EXEC_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_active |-> $past(exec_en)); // R10
endmodule

// File: rtl/cond_xfer_unit.sv
module cond_xfer_unit
    import cxu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exec_en,
    input  logic [INSTR_W-1:0] instr,
    input  logic [IDX_W-1:0]   peek_idx,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  peek_data
);
    logic [INSTR_W-1:0] ir;
    logic               exec_active;
    logic [IDX_W-1:0]   src_idx, dst_idx;
    logic [DATA_W-1:0]  src_val, dst_val, xfer_data;
    logic               write_ok;

    cxu_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .exec_en     (exec_en),
        .instr       (instr),
        .ir          (ir),
        .exec_active (exec_active)
    );

    cxu_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec (
        .ir       (ir),
        .src_val  (src_val),
        .dst_val  (dst_val),
        .src_idx  (src_idx),
        .dst_idx  (dst_idx),
        .write_ok (write_ok),
        .data     (xfer_data)
    );

    cxu_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_en),
        .w_idx    (wr_idx),
        .w_data   (wr_data),
        .src_idx  (src_idx),
        .dst_idx  (dst_idx),
        .peek_idx (peek_idx),
        .src_val  (src_val),
        .dst_val  (dst_val),
        .peek_val (peek_data)
    );

    assign wr_en   = exec_active & write_ok;
    assign wr_idx  = dst_idx;
    assign wr_data = xfer_data;

    AST_LISTED_OPCODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(instr[15:12]) inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6})); // R8

    AST_CONST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (ir[15:12] inside {4'd2, 4'd5, 4'd6})) |-> (wr_data[15:8] == 8'h00)); // R3

    AST_IFZ_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (ir[15:12] inside {4'd3, 4'd5})) |-> (dst_val == '0)); // R4

    AST_IFNZ_NEEDS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (ir[15:12] inside {4'd4, 4'd6})) |-> (dst_val != '0)); // R5
endmodule

// File: tb/cond_xfer_unit_tb.sv
module cond_xfer_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_en = 1'b0;
    logic [15:0] instr = '0;
    logic [3:0]  peek_idx = '0;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [15:0] wr_data, peek_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cond_xfer_unit dut_i (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr),
        .peek_idx(peek_idx), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .peek_data(peek_data)
    );

    typedef struct packed {
        logic [15:0] ins;
        logic        we;
        logic [15:0] data;
        logic [3:0]  idx;
        logic [15:0] val;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{16'h25A1, 1'b1, 16'h005A, 4'd1,  16'h005A, 8'd3},  // R3 const r1
        '{16'h2FF2, 1'b1, 16'h00FF, 4'd2,  16'h00FF, 8'd3},  // R3 const r2
        '{16'h1103, 1'b1, 16'h005A, 4'd3,  16'h005A, 8'd2},  // R2 copy r1->r3
        '{16'h3204, 1'b1, 16'h00FF, 4'd4,  16'h00FF, 8'd4},  // R4 r4 zero, writes
        '{16'h3203, 1'b0, 16'h0000, 4'd3,  16'h005A, 8'd4},  // R4 r3 non-zero, held
        '{16'h4203, 1'b1, 16'h00FF, 4'd3,  16'h00FF, 8'd5},  // R5 r3 non-zero, writes
        '{16'h4105, 1'b0, 16'h0000, 4'd5,  16'h0000, 8'd5},  // R5 r5 zero, held
        '{16'h53C5, 1'b1, 16'h003C, 4'd5,  16'h003C, 8'd6},  // R6 r5 zero, writes
        '{16'h5115, 1'b0, 16'h0000, 4'd5,  16'h003C, 8'd6},  // R6 r5 non-zero, held
        '{16'h6775, 1'b1, 16'h0077, 4'd5,  16'h0077, 8'd7},  // R7 r5 non-zero, writes
        '{16'h6776, 1'b0, 16'h0000, 4'd6,  16'h0000, 8'd7},  // R7 r6 zero, held
        '{16'h0126, 1'b0, 16'h0000, 4'd6,  16'h0000, 8'd8},  // R8 opcode 0000
        '{16'h7126, 1'b0, 16'h0000, 4'd6,  16'h0000, 8'd8},  // R8 opcode 0111
        '{16'hF1F6, 1'b0, 16'h0000, 4'd6,  16'h0000, 8'd8},  // R8 opcode 1111
        '{16'h200F, 1'b1, 16'h0000, 4'd15, 16'h0000, 8'd3},  // R3 zero constant into r15
        '{16'h1500, 1'b1, 16'h0077, 4'd0,  16'h0077, 8'd2}   // R2 copy r5->r0
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Strobe at a falling edge; write port sampled at the next falling edge,
    // register contents one falling edge later (R9).
    task automatic run(input vec_t v, input string req);
        exec_en = 1'b1;
        instr   = v.ins;
        @(negedge clk);
        exec_en = 1'b0;
        chk({req, " wr_en"}, {15'd0, wr_en}, {15'd0, v.we});
        if (v.we) begin
            chk({req, " wr_idx"}, {12'd0, wr_idx}, {12'd0, v.idx});
            chk({req, " wr_data"}, wr_data, v.data);
        end
        @(negedge clk);
        peek_idx = v.idx;
        #1;
        chk({req, " reg"}, peek_data, v.val);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(8 * 50000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 wr_en", {15'd0, wr_en}, 16'd0);
        for (int i = 0; i < 16; i++) begin
            peek_idx = 4'(i);
            #1;
            chk("R1 reg", peek_data, 16'h0000);
        end

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            run(VECS[i], $sformatf("R%0d vec%0d", VECS[i].req, i));
        end

        // R10: instruction present but strobe low
        instr = 16'h2AB9;
        exec_en = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R10 wr_en idle", {15'd0, wr_en}, 16'd0);
        end
        peek_idx = 4'd9;
        #1;
        chk("R10 r9 untouched", peek_data, 16'h0000);

        // R9: back-to-back, second condition sees first result
        exec_en = 1'b1;
        instr = 16'h2448;            // const 0x44 -> r8
        @(negedge clk);
        chk("R9 b2b first wr_en", {15'd0, wr_en}, 16'd1);
        instr = 16'h5998;            // const-if-zero 0x99 -> r8
        @(negedge clk);
        exec_en = 1'b0;
        chk("R9 b2b second wr_en", {15'd0, wr_en}, 16'd0);
        @(negedge clk);
        peek_idx = 4'd8;
        #1;
        chk("R9 b2b r8", peek_data, 16'h0044);

        exec_en = 1'b1;
        instr = 16'h5109;            // const-if-zero 0x10 -> r9 (r9 zero)
        @(negedge clk);
        chk("R9 R6 first wr_data", wr_data, 16'h0010);
        instr = 16'h5209;            // const-if-zero 0x20 -> r9 (now 0x10)
        @(negedge clk);
        exec_en = 1'b0;
        chk("R9 R6 second wr_en", {15'd0, wr_en}, 16'd0);
        @(negedge clk);
        peek_idx = 4'd9;
        #1;
        chk("R9 r9 final", peek_data, 16'h0010);

        // R2 with high bits: copy r8 to r10 while peeking old r10 pre-write
        exec_en = 1'b1;
        instr = 16'h180A;
        @(negedge clk);
        exec_en = 1'b0;
        peek_idx = 4'd10;
        #1;
        chk("R9 pre-write r10", peek_data, 16'h0000);
        chk("R2 copy data", wr_data, 16'h0044);
        @(negedge clk);
        #1;
        chk("R2 r10 after", peek_data, 16'h0044);

        finished = 1'b1;
        summary();
    end
endmodule